// File: doc/BRIEF.md
# Internal Oscillator Rate Divider and Selector

This block turns three free-running oscillator tick trains into a single system clock-enable train, `sys_tick`. The three inputs are a fast 16 MHz source, a medium 500 kHz source and a separate 31.25 kHz low-rate oscillator. Each input is a single-cycle pulse in the `clk` domain, and the low-rate oscillator cannot be tuned. One power-of-two divider counts ticks of the selected source. Its terminal count produces one output pulse. The output rates range from 16 MHz down to about 31 kHz.

The rate comes from a 3-bit code and two steering bits. `mf_select` chooses whether the 500 kHz and 250 kHz rates, and the divided form of the lowest rate, are taken from the medium source or from the fast source. `lf_divided` chooses whether the lowest rate comes directly from the low-rate oscillator or from dividing a source. A new selection is latched only at the divider's terminal count, so the current output period always completes at its old length. Reset forces the 1 MHz setting, meaning the fast source divided by 16, until the first terminal count after reset.

The block has no data stream, so it has no valid/ready handshake and no back-pressure. All pins are plain control signals.

Top module: `intosc_rate_gen`

## Requirements
- R1: In the cycles after reset the divider counts from zero at the 1 MHz setting (fast source divided by 16), whatever the select inputs are. The first `sys_tick` appears on the 16th fast tick after reset is released.
- R2: Rate codes 3'b111, 3'b110, 3'b101, 3'b100 and 3'b011 give one output pulse per 1, 2, 4, 8 and 16 fast-source ticks.
- R3: Codes 3'b010 and 3'b001 give one pulse per 32 and 64 fast ticks when `mf_select`=0. They give one pulse per 1 and 2 medium ticks when `mf_select`=1.
- R4: Code 3'b000 with `lf_divided`=0 gives exactly one output pulse per low-rate oscillator tick.
- R5: Code 3'b000 with `lf_divided`=1 gives one pulse per 512 fast ticks when `mf_select`=0, and one pulse per 16 medium ticks when `mf_select`=1.
- R6: `mf_select` has no effect for codes 3'b011 to 3'b111. `lf_divided` has no effect for codes 3'b001 to 3'b111.
- R7: A change of `rate_code`, `mf_select` or `lf_divided` takes effect only at the next terminal count, so the period in progress keeps its old length. Each `sys_tick` is one `clk` cycle long and is registered one cycle after the terminal source tick.
- R8: The divider advances only on a tick of the source in use. It keeps its position while that source is idle and never passes its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all ticks are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hf_tick | input | 1 | One-cycle pulse per period of the 16 MHz source |
| mf_tick | input | 1 | One-cycle pulse per period of the 500 kHz source |
| lf_tick | input | 1 | One-cycle pulse per period of the 31.25 kHz oscillator |
| rate_code | input | 3 | Output rate code (3'b111 fastest, 3'b000 lowest) |
| mf_select | input | 1 | 1: medium source feeds the lower rates; 0: fast source does |
| lf_divided | input | 1 | Lowest rate: 0 uses the low-rate oscillator directly, 1 a divided source |
| sys_tick | output | 1 | One-cycle enable pulse at the selected rate |

## Verification
A divider counter that drifts or loads a wrong terminal value shows up as a wrong interval between `sys_tick` pulses. The error appears on the first full period after the fault, so it is visible within one output period, at most 640 `clk` cycles at the slowest setting the bench uses. A selection latched at the wrong moment, or a reset that leaves the wrong selection in place, shows up one pulse earlier: the period in progress ends early or late. Sweeping every code and steering combination with the three sources at distinct rates makes each possible routing produce its own interval. A source or tap swapped by mistake therefore cannot hide behind an equal period.

// File: rtl/intosc_rate_pkg.sv
package intosc_rate_pkg;
  localparam int SHIFT_W = 4;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MED  = 2'd1,
    SRC_LOW  = 2'd2
  } src_e;

  typedef struct packed {
    src_e               src;
    logic [SHIFT_W-1:0] shift;
  } div_cfg_t;
endpackage

// File: rtl/rate_decode.sv
module rate_decode
  import intosc_rate_pkg::*;
#(
  parameter int MF_LOG2  = 5,
  parameter int LOW_LOG2 = 4
) (
  input  logic [2:0] rate_code,
  input  logic       mf_select,
  input  logic       lf_divided,
  output div_cfg_t   cfg
);
  always_comb begin
    cfg.src   = SRC_FAST;
    cfg.shift = '0;
    case (rate_code)
      3'd2: begin
        cfg.src   = mf_select ? SRC_MED : SRC_FAST;
        cfg.shift = mf_select ? SHIFT_W'(0) : SHIFT_W'(MF_LOG2);
      end
      3'd1: begin
        cfg.src   = mf_select ? SRC_MED : SRC_FAST;
        cfg.shift = mf_select ? SHIFT_W'(1) : SHIFT_W'(MF_LOG2 + 1);
      end
      3'd0: begin
        if (!lf_divided) begin
          cfg.src   = SRC_LOW;
          cfg.shift = '0;
        end else if (mf_select) begin
          cfg.src   = SRC_MED;
          cfg.shift = SHIFT_W'(LOW_LOG2);
        end else begin
          cfg.src   = SRC_FAST;
          cfg.shift = SHIFT_W'(MF_LOG2 + LOW_LOG2);
        end
      end
      default: begin
        cfg.src   = SRC_FAST;
        cfg.shift = SHIFT_W'(3'd7 - rate_code);
      end
    endcase
  end
endmodule

// File: rtl/src_select.sv
module src_select
  import intosc_rate_pkg::*;
(
  input  src_e src,
  input  logic hf_tick,
  input  logic mf_tick,
  input  logic lf_tick,
  output logic src_tick
);
  always_comb begin
    case (src)
      SRC_MED: src_tick = mf_tick;
      SRC_LOW: src_tick = lf_tick;
      default: src_tick = hf_tick;
    endcase
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import intosc_rate_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [SHIFT_W-1:0] shift,
  output logic               term
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   span;

  always_comb begin
    span  = (CNT_W+1)'(1) << shift;
    limit = CNT_W'(span - 1'b1);
    term  = tick && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == limit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assert_count_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);

  assert_count_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/intosc_rate_gen.sv
module intosc_rate_gen
  import intosc_rate_pkg::*;
#(
  parameter int MF_LOG2  = 5,
  parameter int LOW_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hf_tick,
  input  logic       mf_tick,
  input  logic       lf_tick,
  input  logic [2:0] rate_code,
  input  logic       mf_select,
  input  logic       lf_divided,
  output logic       sys_tick
);
  localparam int       CNT_W         = MF_LOG2 + LOW_LOG2;
  localparam int       DEFAULT_SHIFT = 7 - 3;
  localparam div_cfg_t DEFAULT_CFG   = '{src: SRC_FAST, shift: SHIFT_W'(DEFAULT_SHIFT)};

  div_cfg_t req_cfg;
  div_cfg_t active_cfg;
  logic     src_tick;
  logic     term;

  rate_decode #(.MF_LOG2(MF_LOG2), .LOW_LOG2(LOW_LOG2)) u_decode (
    .rate_code (rate_code),
    .mf_select (mf_select),
    .lf_divided(lf_divided),
    .cfg       (req_cfg)
  );

  src_select u_select (
    .src     (active_cfg.src),
    .hf_tick (hf_tick),
    .mf_tick (mf_tick),
    .lf_tick (lf_tick),
    .src_tick(src_tick)
  );

  tick_divider #(.CNT_W(CNT_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (src_tick),
    .shift(active_cfg.shift),
    .term (term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_cfg <= DEFAULT_CFG;
      sys_tick   <= 1'b0;
    end else begin
      if (term) active_cfg <= req_cfg;
      sys_tick <= term;
    end
  end

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(active_cfg));

  assert_pulse_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
    sys_tick |-> $past(src_tick));

  assert_low_direct_R4: assert property (@(posedge clk) disable iff (rst)
    (active_cfg.src == SRC_LOW) |-> (active_cfg.shift == '0));

  assert_fast_codes_R6: assert property (@(posedge clk) disable iff (rst)
    (rate_code >= 3'd3) |-> (req_cfg.src == SRC_FAST));
endmodule

// File: tb/intosc_rate_gen_bench.sv
module intosc_rate_gen_bench;
  localparam int MF_PER  = 40;
  localparam int LF_PER  = 300;
  localparam int TIMEOUT = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hf_tick = 1'b0;
  logic       mf_tick = 1'b0;
  logic       lf_tick = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic       mf_select = 1'b0;
  logic       lf_divided = 1'b0;
  logic       sys_tick;
  logic       hf_en = 1'b1;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  intosc_rate_gen u_intosc_rate_gen (
    .clk(clk), .rst(rst), .hf_tick(hf_tick), .mf_tick(mf_tick),
    .lf_tick(lf_tick), .rate_code(rate_code), .mf_select(mf_select),
    .lf_divided(lf_divided), .sys_tick(sys_tick)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      hf_tick = hf_en;
      mf_tick = (cyc % MF_PER) == 0;
      lf_tick = (cyc % LF_PER) == 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(string req, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_tick && n < TIMEOUT);
    if (!sys_tick) begin
      checks++;
      fails++;
      $display("FAIL %s actual=no pulse expected=pulse within %0d", req, TIMEOUT);
    end
  endtask

  function automatic int exp_period(int code, int mf, int lf);
    if (code >= 3) return 1 << (7 - code);
    if (code == 0 && lf == 0) return LF_PER;
    if (mf == 1) return MF_PER * ((code == 2) ? 1 : (code == 1) ? 2 : 16);
    return (code == 2) ? 32 : (code == 1) ? 64 : 512;
  endfunction

  function automatic string tag_of(int code, int mf, int lf);
    if (code >= 3) return (mf != 0 || lf != 0) ? "R6/R2" : "R2";
    if (code != 0) return (lf != 0) ? "R6/R3" : "R3";
    return (lf == 0) ? "R4" : "R5";
  endfunction

  initial begin
    int n;
    // R1: default rate after reset, select inputs set to a different rate
    rate_code = 3'd7;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_pulse("R1", n);
    check("R1 first pulse after reset", n, 16);
    wait_pulse("R7", n);
    check("R7 new code after terminal", n, 1);

    // Full sweep of code and steering bits (R2..R6)
    for (int code = 7; code >= 0; code--) begin
      for (int mf = 0; mf < 2; mf++) begin
        for (int lf = 0; lf < 2; lf++) begin
          string tg;
          tg = tag_of(code, mf, lf);
          rate_code  = 3'(code);
          mf_select  = 1'(mf);
          lf_divided = 1'(lf);
          wait_pulse(tg, n);
          wait_pulse(tg, n);
          for (int k = 0; k < 3; k++) begin
            wait_pulse(tg, n);
            check($sformatf("%s code=%0d mf=%0d lf=%0d", tg, code, mf, lf),
                  n, exp_period(code, mf, lf));
          end
        end
      end
    end

    // R7: change mid-period keeps the running period
    rate_code = 3'd4; mf_select = 1'b0; lf_divided = 1'b0;
    wait_pulse("R7", n);
    wait_pulse("R7", n);
    rate_code = 3'd7;
    wait_pulse("R7", n);
    check("R7 old period completes", n, 8);
    wait_pulse("R7", n);
    check("R7 new period applied", n, 1);

    // R8: idle source freezes the divider
    rate_code = 3'd5;
    wait_pulse("R8", n);
    wait_pulse("R8", n);
    repeat (2) @(negedge clk);
    hf_en = 1'b0;
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (sys_tick) highs++;
      end
      check("R8 no pulse while source idle", highs, 0);
    end
    hf_en = 1'b1;
    wait_pulse("R8", n);
    check("R8 count resumes from held position", n, 2);

    // R1: reset mid-run restores default
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_pulse("R1", n);
    check("R1 default after second reset", n, 16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule